// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates among thirteen interrupt sources for a small processor core. Each source supplies a request flag, an enable bit and two priority bits that together select one of four levels. A global enable gates every source at once. Every cycle the controller looks for the best pending request that can preempt the work already in progress. It presents that request on a registered strobe, together with the source's vector address, its level and its source index.

The core accepts a presented request with a one-cycle acknowledge pulse, which marks that level as in service. A return pulse at the end of a handler retires the highest level that is in service. A request is offered only when its level is strictly above every level in service, so handlers nest up to four deep and the top level is never interrupted. When several requests sit at the same level, a fixed ranking picks one. That ranking differs from the order of the vector addresses.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A source whose bit in `src_en` is 0 is never presented, whatever its request and level.
- R2: While `glb_en` is 0, no source is presented, and `irq_valid` is 0 on the following cycle.
- R3: A source's level is `{prio_hi[i], prio_lo[i]}`, from 0 (lowest) to 3 (highest). Among eligible requests, the highest level wins and is shown on `irq_level`.
- R4: A request is eligible only if its level is strictly greater than the highest set bit of `active_lvls`. While bit 3 is set, nothing is presented.
- R5: Among eligible requests at the winning level, the winner is the first in this source-index order: 0, 5, 9, 1, 6, 10, 2, 7, 11, 3, 8, 4, 12. `irq_src` shows the winner's index.
- R6: The vector addresses for source indices 0 to 12 are, in hex: 03, 0B, 13, 1B, 23, 2B, 33, 3B, 43, 53, 5B, 63, 73. While `irq_valid` is 0, `irq_vector` is 0.
- R7: An `ack` pulse while `irq_valid` is 1 sets bit `irq_level` of `active_lvls` at the next edge. An `ack` pulse while `irq_valid` is 0 has no effect.
- R8: A `reti` pulse clears the highest set bit of `active_lvls`. With `active_lvls` equal to 0, it has no effect. When `reti` and an accepted `ack` arrive in the same cycle, the clear applies to the old bits and the new bit is then set.
- R9: The outputs are registered. They reflect the inputs sampled at one edge and the in-service bits produced at that same edge, so a just-acknowledged request is not offered again.
- R10: After reset, `irq_valid`, `irq_level`, `irq_src`, `irq_vector` and `active_lvls` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 13 | Request flag per source |
| src_en | input | 13 | Enable per source |
| prio_hi | input | 13 | High priority bit per source |
| prio_lo | input | 13 | Low priority bit per source |
| glb_en | input | 1 | Global enable for all sources |
| ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Core returns from the current handler |
| irq_valid | output | 1 | A request is presented |
| irq_vector | output | 16 | Vector address of the presented source |
| irq_level | output | 2 | Level of the presented source |
| irq_src | output | 4 | Index of the presented source |
| active_lvls | output | 4 | In-service level bits |

## Verification
A wrong in-service bit shows up on `active_lvls` at the very next edge. It also shows up in which requests are offered: a bit that stays set wrongly hides eligible requests, and a bit that is lost lets equal or lower levels preempt. The bench compares all outputs on every cycle against a behavioural model, so a fault in the ranking, vector mapping or level decoding is reported on the first cycle a competing request pattern reaches it. Directed sequences build nesting up to the top level and unwind it, and a long random phase mixes acknowledges and returns.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int SRC_COUNT = 13;
    localparam int LVL_COUNT = 4;
    localparam int LVL_W     = 2;
    localparam int VEC_W     = 16;

    // Vector slot skips unused positions after index 8 and index 11.
    function automatic logic [VEC_W-1:0] vector_of(input int idx);
        int slot;
        slot = idx + ((idx >= 9) ? 1 : 0) + ((idx >= 12) ? 1 : 0);
        return VEC_W'(3 + 8 * slot);
    endfunction

    // Source index at tie-break position r (position 0 wins).
    function automatic int order_at(input int r);
        case (r)
            0:       return 0;
            1:       return 5;
            2:       return 9;
            3:       return 1;
            4:       return 6;
            5:       return 10;
            6:       return 2;
            7:       return 7;
            8:       return 11;
            9:       return 3;
            10:      return 8;
            11:      return 4;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_mask.sv
module irq_src_mask #(
    parameter int N  = 13,
    parameter int LW = 2
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0]         en,
    input  logic [N-1:0]         hi,
    input  logic [N-1:0]         lo,
    input  logic                 glb,
    input  logic [LW:0]          floor_lvl,
    output logic [N-1:0]         elig,
    output logic [N-1:0][LW-1:0] lvl
);

    for (genvar g = 0; g < N; g++) begin : g_src
        assign lvl[g]  = LW'({hi[g], lo[g]});
        assign elig[g] = req[g] && en[g] && glb && ({1'b0, lvl[g]} >= floor_lvl);
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 13,
    parameter int LW = 2,
    parameter int IW = 4
) (
    input  logic [N-1:0]         elig,
    input  logic [N-1:0][LW-1:0] lvl,
    output logic                 found,
    output logic [LW-1:0]        best_lvl,
    output logic [IW-1:0]        best_idx
);

    // Walk in tie-break order; only a strictly higher level displaces the holder.
    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_idx = '0;
        for (int r = 0; r < N; r++) begin
            if (elig[irq_ctrl_pkg::order_at(r)] &&
                (!found || lvl[irq_ctrl_pkg::order_at(r)] > best_lvl)) begin
                found    = 1'b1;
                best_lvl = lvl[irq_ctrl_pkg::order_at(r)];
                best_idx = IW'(irq_ctrl_pkg::order_at(r));
            end
        end
    end

endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track #(
    parameter int NL = 4,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [LW-1:0] fire_lvl,
    input  logic          reti,
    output logic [NL-1:0] isr_q,
    output logic [LW:0]   floor_d
);

    typedef struct packed {
        logic [NL-1:0] isr;
    } trk_t;

    trk_t          st_d, st_q;
    logic [NL-1:0] top_oh;

    always_comb begin
        top_oh = '0;
        for (int l = 0; l < NL; l++) begin
            if (st_q.isr[l]) top_oh = NL'(1) << l;
        end
        st_d     = st_q;
        st_d.isr = st_q.isr & ~(reti ? top_oh : '0);
        if (fire) st_d.isr[fire_lvl] = 1'b1;
        floor_d = '0;
        for (int l = 0; l < NL; l++) begin
            if (st_d.isr[l]) floor_d = (LW+1)'(l + 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isr_q = st_q.isr;

    AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !fire && st_q.isr != '0) |=> $countones(st_q.isr) == $countones($past(st_q.isr)) - 1); // R8
    AST_RETI_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !fire && st_q.isr == '0) |=> st_q.isr == '0); // R8

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
    parameter int NUM_SRC = irq_ctrl_pkg::SRC_COUNT,
    parameter int VEC_W   = irq_ctrl_pkg::VEC_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            src_req,
    input  logic [NUM_SRC-1:0]            src_en,
    input  logic [NUM_SRC-1:0]            prio_hi,
    input  logic [NUM_SRC-1:0]            prio_lo,
    input  logic                          glb_en,
    input  logic                          ack,
    input  logic                          reti,
    output logic                          irq_valid,
    output logic [VEC_W-1:0]              irq_vector,
    output logic [irq_ctrl_pkg::LVL_W-1:0] irq_level,
    output logic [$clog2(NUM_SRC)-1:0]    irq_src,
    output logic [irq_ctrl_pkg::LVL_COUNT-1:0] active_lvls
);

    localparam int LW = irq_ctrl_pkg::LVL_W;
    localparam int NL = irq_ctrl_pkg::LVL_COUNT;
    localparam int IW = $clog2(NUM_SRC);

    typedef struct packed {
        logic             valid;
        logic [LW-1:0]    lvl;
        logic [IW-1:0]    src;
        logic [VEC_W-1:0] vec;
    } out_t;

    out_t                        out_d, out_q;
    logic                        fire;
    logic [LW:0]                 floor_d;
    logic [NL-1:0]               isr_q;
    logic [NUM_SRC-1:0]          elig;
    logic [NUM_SRC-1:0][LW-1:0]  lvl;
    logic                        found;
    logic [LW-1:0]               best_lvl;
    logic [IW-1:0]               best_idx;

    assign fire = ack && out_q.valid;

    irq_isr_track #(.NL(NL), .LW(LW)) u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .fire_lvl (out_q.lvl),
        .reti     (reti),
        .isr_q    (isr_q),
        .floor_d  (floor_d)
    );

    irq_src_mask #(.N(NUM_SRC), .LW(LW)) u_mask (
        .req       (src_req),
        .en        (src_en),
        .hi        (prio_hi),
        .lo        (prio_lo),
        .glb       (glb_en),
        .floor_lvl (floor_d),
        .elig      (elig),
        .lvl       (lvl)
    );

    irq_pick #(.N(NUM_SRC), .LW(LW), .IW(IW)) u_pick (
        .elig     (elig),
        .lvl      (lvl),
        .found    (found),
        .best_lvl (best_lvl),
        .best_idx (best_idx)
    );

    always_comb begin
        out_d       = '0;
        out_d.valid = found;
        out_d.lvl   = best_lvl;
        out_d.src   = best_idx;
        out_d.vec   = found ? VEC_W'(irq_ctrl_pkg::vector_of(int'(best_idx))) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_valid   = out_q.valid;
    assign irq_vector  = out_q.vec;
    assign irq_level   = out_q.lvl;
    assign irq_src     = out_q.src;
    assign active_lvls = isr_q;

    AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_valid) |=> active_lvls[$past(irq_level)]); // R7
    AST_ABOVE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (active_lvls >> irq_level) == '0); // R4
    AST_TOP_LEVEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        active_lvls[NL-1] |-> !irq_valid); // R4
    AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !irq_valid); // R2
    AST_VECTOR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_vector[2:0] == 3'b011); // R6

endmodule

// File: tb/nested_irq_ctrl_tb.sv
module nested_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] req, en, hi, lo;
    logic        glb, ack, reti;
    logic        irq_valid;
    logic [15:0] irq_vector;
    logic [1:0]  irq_level;
    logic [3:0]  irq_src;
    logic [3:0]  active_lvls;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int ORD[13] = '{0, 5, 9, 1, 6, 10, 2, 7, 11, 3, 8, 4, 12};
    int VEC[13] = '{'h03, 'h0B, 'h13, 'h1B, 'h23, 'h2B, 'h33, 'h3B, 'h43, 'h53, 'h5B, 'h63, 'h73};

    bit [3:0] m_isr;
    bit       m_valid;
    int       m_lvl, m_src, m_vec;

    always #10 clk = ~clk;

    nested_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(req), .src_en(en),
        .prio_hi(hi), .prio_lo(lo), .glb_en(glb), .ack(ack), .reti(reti),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
        .irq_src(irq_src), .active_lvls(active_lvls)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_next();
        bit [3:0] nisr;
        int top, bl, bi;
        bit fnd;
        nisr = m_isr;
        if (reti) begin
            for (int l = 3; l >= 0; l--) if (nisr[l]) begin nisr[l] = 0; break; end
        end
        if (ack && m_valid) nisr[m_lvl] = 1;
        top = -1;
        for (int l = 0; l < 4; l++) if (nisr[l]) top = l;
        fnd = 0; bl = 0; bi = 0;
        for (int r = 0; r < 13; r++) begin
            int i, l;
            i = ORD[r];
            l = hi[i] * 2 + lo[i];
            if (req[i] && en[i] && glb && l > top && (!fnd || l > bl)) begin
                fnd = 1; bl = l; bi = i;
            end
        end
        m_isr   = nisr;
        m_valid = fnd;
        m_lvl   = fnd ? bl : 0;
        m_src   = fnd ? bi : 0;
        m_vec   = fnd ? VEC[bi] : 0;
    endtask

    // Called at a negedge with the new inputs set; compares after the next edge.
    task automatic step();
        model_next();
        @(negedge clk);
        chk(irq_valid == m_valid, "R9 valid", irq_valid, m_valid);
        chk(irq_level == m_lvl, "R3 level", irq_level, m_lvl);
        chk(irq_src == m_src, "R5 source", irq_src, m_src);
        chk(irq_vector == m_vec, "R6 vector", irq_vector, m_vec);
        chk(active_lvls == m_isr, "R7 active", active_lvls, m_isr);
        ack = 0; reti = 0;
    endtask

    task automatic set_src(input int i, input int l);
        req[i] = 1; hi[i] = l[1]; lo[i] = l[0];
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req = 0; en = '1; hi = 0; lo = 0; glb = 1; ack = 0; reti = 0;
        m_isr = 0; m_valid = 0; m_lvl = 0; m_src = 0; m_vec = 0;
        repeat (3) @(negedge clk);
        chk(irq_valid == 0 && irq_vector == 0 && active_lvls == 0 && irq_src == 0 && irq_level == 0,
            "R10 reset", {irq_valid, active_lvls}, 0);
        rst_n = 1;
        @(negedge clk);

        set_src(2, 1); step();
        chk(irq_vector == 16'h13 && irq_level == 1, "R6 ext1 vector", irq_vector, 'h13);
        en[2] = 0; step();
        chk(irq_valid == 0, "R1 disabled source", irq_valid, 0);
        en[2] = 1; glb = 0; step();
        chk(irq_valid == 0, "R2 global off", irq_valid, 0);
        glb = 1; req = 0;
        set_src(2, 0); set_src(7, 0); step();
        chk(irq_src == 2 && irq_vector == 16'h13, "R5 tie 2 over 7", irq_src, 2);
        req = 0; set_src(1, 2); set_src(5, 2); step();
        chk(irq_src == 5 && irq_vector == 16'h2B, "R5 tie 5 over 1", irq_src, 5);
        req = 0; set_src(0, 0); set_src(12, 2); step();
        chk(irq_src == 12 && irq_level == 2, "R3 higher level wins", irq_src, 12);
        ack = 1; step();
        chk(active_lvls == 4'b0100 && irq_valid == 0, "R7 ack marks level", active_lvls, 4);
        ack = 1; step();
        chk(active_lvls == 4'b0100, "R7 ack ignored when idle", active_lvls, 4);
        set_src(0, 3); step();
        chk(irq_valid == 1 && irq_vector == 16'h03, "R4 preempt by level 3", irq_vector, 3);
        ack = 1; step();
        chk(active_lvls == 4'b1100, "R7 nested ack", active_lvls, 'hC);
        set_src(9, 3); set_src(3, 3); step();
        chk(irq_valid == 0, "R4 top level not preempted", irq_valid, 0);
        req = 0; reti = 1; step();
        chk(active_lvls == 4'b0100, "R8 reti drops top", active_lvls, 4);
        reti = 1; step();
        chk(active_lvls == 4'b0000, "R8 reti drops last", active_lvls, 0);
        reti = 1; step();
        chk(active_lvls == 4'b0000, "R8 reti on empty", active_lvls, 0);

        for (int k = 0; k < 5000; k++) begin
            req  = 13'($urandom & $urandom);
            en   = ~13'($urandom & $urandom & $urandom);
            hi   = 13'($urandom);
            lo   = 13'($urandom);
            glb  = ($urandom % 8) != 0;
            ack  = m_valid ? ($urandom % 2) : (($urandom % 4) == 0);
            reti = ($urandom % 4) == 0;
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule